// File: doc/BRIEF.md
# Seconds Adjust and Carry Control

This block keeps the two BCD seconds digits of a time-of-day clock and controls how they advance. A once-per-second carry from the sub-second divider normally moves the seconds on by one, and rolling over from 59 to 00 sends a one-cycle request to the minute counter. Software can round the time to the nearest minute, clear the fractional-second divider stages, preset the seconds, and pause counting. A carry that arrives while counting is paused is remembered, and it is applied as a single +1 second when counting resumes.

A busy flag tells software when the seconds are being changed, so it does not read them at the wrong moment. The flag is timed in periods of the 32.768 kHz tick. It starts one tick before a normal carry takes effect, and it stays high for a fixed number of ticks after each command or correction. All logic runs on one system clock. The tick and the 1 Hz carry arrive as one-cycle enable pulses, and each command arrives as a one-cycle write strobe.

Top module: `sec_adjust_ctrl`

## Requirements
- R1: After reset the seconds read 00, busy, min_inc and div_rst are 0, and counting is enabled.
- R2: With counting enabled, a carry_1hz pulse advances the seconds by one at the first tick_32k pulse after it. The seconds are two BCD digits: sec_ones runs 0 to 9 and sec_tens runs 0 to 5.
- R3: An advance from 59 wraps the seconds to 00 and pulses min_inc for one cycle.
- R4: A wr_adjust strobe while the seconds are 00 to 29 sets them to 00 and pulses div_rst, and min_inc stays 0.
- R5: A wr_adjust strobe while the seconds are 30 to 59 sets them to 00, pulses div_rst and pulses min_inc once.
- R6: A wr_divrst strobe pulses div_rst for one cycle and leaves the seconds unchanged.
- R7: A wr_cen strobe with cen_wdata=0 pauses counting, and carries do not change the seconds while counting is paused. When counting resumes, the seconds advance by exactly one if at least one carry was missed, and they do not change if none was missed.
- R8: While chip_en is 0, counting is forced on. This resumes a paused count as described in R7.
- R9: After wr_adjust, wr_divrst or a resume correction, busy is 1 from the next cycle until four tick_32k pulses have passed.
- R10: After an accepted carry, busy is 1 from the next cycle. The seconds advance at the first tick after the carry, and busy falls at the third tick.
- R11: A wr_adjust in the same cycle as a carry_1hz, or while a carry is waiting for its tick, discards that carry.
- R12: A wr_sec strobe loads sec_wdata, with the ones digit in bits 3:0 and the tens digit in bits 6:4, and the value must be valid BCD. A load overrides an advance in the same cycle, and wr_adjust overrides a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle pulse at 32.768 kHz rate |
| carry_1hz | input | 1 | One-cycle carry pulse from the divider |
| chip_en | input | 1 | Chip enable; low forces counting on |
| wr_adjust | input | 1 | Round-to-minute command strobe |
| wr_divrst | input | 1 | Divider-reset command strobe |
| wr_cen | input | 1 | Carry-enable write strobe |
| cen_wdata | input | 1 | Carry-enable value written |
| wr_sec | input | 1 | Seconds preset strobe |
| sec_wdata | input | 7 | Seconds preset value, tens in 6:4 and ones in 3:0 |
| sec_ones | output | 4 | Seconds ones digit |
| sec_tens | output | 3 | Seconds tens digit |
| min_inc | output | 1 | One-cycle minute increment request |
| div_rst | output | 1 | One-cycle reset for the 8 Hz to 1 Hz divider stages |
| busy | output | 1 | Seconds update in progress |

## Verification
On every cycle, the assertions check that the digits stay within BCD range and that a minute request only comes with seconds at 00. They also check that an adjust always leaves 00, that a missed carry is only held while counting is paused, that a low chip enable turns counting on, and that every command raises div_rst or busy on the next cycle. Other behaviour can only be shown by the bench scenarios. These include the exact length of each busy window in ticks, the single +1 after several missed carries, the 29/30 rounding boundary, and the rule that an adjust discards a carry in the same cycle. A reference model in the bench also follows long random mixes of these events.

// File: rtl/secadj_pkg.sv
// Package: shared constants and helpers for the seconds adjust block.
// Assumes seconds are two BCD digits, ones 0..9 and tens 0..5.
package secadj_pkg;

    localparam int ONES_W    = 4;
    localparam int TENS_W    = 3;
    localparam int ONES_LAST = 9;
    localparam int TENS_LAST = 5;
    localparam int ROUND_UP_TENS = 3;

    typedef struct packed {
        logic [TENS_W-1:0] tens;
        logic [ONES_W-1:0] ones;
    } bcd_sec_t;

    // Return the larger of two busy reload values.
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sec_bcd_counter.sv
// Module: two-digit BCD seconds register with clear, preset and +1.
// Priority: clear (adjust) over preset over increment. A clear with the
// tens digit at 3 or above, or a wrap from 59, raises a minute request.
// Assumes preset values are valid BCD.
module sec_bcd_counter
    import secadj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_round,
    input  logic              load,
    input  bcd_sec_t          load_val,
    input  logic              inc,
    output bcd_sec_t          sec,
    output logic              min_req
);

    bcd_sec_t sec_q;
    logic     min_q;
    logic     ones_at_last;
    logic     tens_at_last;

    assign ones_at_last = (sec_q.ones == ONES_W'(ONES_LAST));
    assign tens_at_last = (sec_q.tens == TENS_W'(TENS_LAST));

    // Update the digits and the one-cycle minute request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            min_q <= 1'b0;
        end else begin
            min_q <= 1'b0;
            if (clr_round) begin
                sec_q <= '0;
                min_q <= (sec_q.tens >= TENS_W'(ROUND_UP_TENS));
            end else if (load) begin
                sec_q <= load_val;
            end else if (inc) begin
                if (ones_at_last) begin
                    sec_q.ones <= '0;
                    if (tens_at_last) begin
                        sec_q.tens <= '0;
                        min_q      <= 1'b1;
                    end else begin
                        sec_q.tens <= sec_q.tens + 1'b1;
                    end
                end else begin
                    sec_q.ones <= sec_q.ones + 1'b1;
                end
            end
        end
    end

    assign sec     = sec_q;
    assign min_req = min_q;

    AST_SEC_BCD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q.ones <= ONES_W'(ONES_LAST)) && (sec_q.tens <= TENS_W'(TENS_LAST))); // R2
    AST_MIN_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        min_q |-> (sec_q == '0)); // R3
    AST_ADJUST_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_round |=> (sec_q == '0)); // R4

endmodule

// File: rtl/carry_gate.sv
// Module: carry enable, pending carry and missed-carry memory.
// A carry seen while enabled waits for the next tick, then asks for +1.
// A carry seen while paused is remembered and replayed once on resume.
// Adjust discards any waiting or remembered carry.
module carry_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic carry_in,
    input  logic chip_en,
    input  logic wr_cen,
    input  logic cen_wdata,
    input  logic adjust,
    output logic inc,
    output logic corr,
    output logic carry_acc
);

    logic cen_q;
    logic held_q;
    logic pend_q;
    logic cen_nxt;
    logic resume;
    logic pend_due;
    logic missed;

    // Next enable value: a low chip enable forces counting on.
    always_comb begin
        if (!chip_en)    cen_nxt = 1'b1;
        else if (wr_cen) cen_nxt = cen_wdata;
        else             cen_nxt = cen_q;
    end

    assign resume    = cen_nxt & ~cen_q;
    assign pend_due  = pend_q & tick;
    assign missed    = held_q | (~cen_q & (pend_due | carry_in));
    assign corr      = ~adjust & resume & missed;
    assign carry_acc = ~adjust & carry_in & cen_q;
    assign inc       = ~adjust & (corr | (pend_due & cen_q));

    // Track enable, a carry waiting for its tick, and a missed carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cen_q  <= 1'b1;
            held_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            cen_q <= cen_nxt;
            if (adjust) begin
                pend_q <= 1'b0;
            end else begin
                pend_q <= carry_acc | (pend_q & ~tick);
            end
            if (adjust || corr) begin
                held_q <= 1'b0;
            end else begin
                held_q <= held_q | (~cen_q & (pend_due | carry_in));
            end
        end
    end

    AST_HELD_ONLY_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        held_q |-> !cen_q); // R7
    AST_CHIP_OFF_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> cen_q); // R8

endmodule

// File: rtl/busy_window.sv
// Module: busy flag timed in 32.768 kHz ticks.
// Each request reloads the remaining tick count, and the larger of the
// current and requested counts wins. A tick in the reload cycle is not
// counted. Busy is high while the count is non-zero.
module busy_window #(
    parameter int unsigned CMD_TICKS   = 4,
    parameter int unsigned CARRY_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cmd_req,
    input  logic carry_req,
    output logic busy
);

    localparam int unsigned MAX_TICKS = secadj_pkg::max_u(CMD_TICKS, CARRY_TICKS);
    localparam int unsigned CW        = $clog2(MAX_TICKS + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] base;
    logic [CW-1:0] reload;

    assign base = cnt_q - CW'(tick && (cnt_q != '0));

    // Choose the reload value requested this cycle.
    always_comb begin
        if (cmd_req)        reload = CW'(CMD_TICKS);
        else if (carry_req) reload = CW'(CARRY_TICKS);
        else                reload = '0;
    end

    // Count down on ticks, extend on requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= (reload > base) ? reload : base;
        end
    end

    assign busy = (cnt_q != '0);

    AST_BUSY_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_TICKS)); // R9
    AST_BUSY_AFTER_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        carry_req |=> busy); // R10

endmodule

// File: rtl/sec_adjust_ctrl.sv
// Module: top of the seconds adjust and carry control block.
// Joins the carry gate, the BCD seconds counter and the busy timer,
// and produces the divider reset pulse. Assumes all strobes, the tick
// and the carry are single-cycle pulses in the clk domain.
module sec_adjust_ctrl
    import secadj_pkg::*;
#(
    parameter int unsigned CMD_TICKS   = 4,
    parameter int unsigned CARRY_TICKS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_32k,
    input  logic                     carry_1hz,
    input  logic                     chip_en,
    input  logic                     wr_adjust,
    input  logic                     wr_divrst,
    input  logic                     wr_cen,
    input  logic                     cen_wdata,
    input  logic                     wr_sec,
    input  logic [ONES_W+TENS_W-1:0] sec_wdata,
    output logic [ONES_W-1:0]        sec_ones,
    output logic [TENS_W-1:0]        sec_tens,
    output logic                     min_inc,
    output logic                     div_rst,
    output logic                     busy
);

    logic     inc;
    logic     corr;
    logic     carry_acc;
    logic     div_rst_q;
    bcd_sec_t sec;
    bcd_sec_t preset;

    assign preset = bcd_sec_t'(sec_wdata);

    carry_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_32k),
        .carry_in  (carry_1hz),
        .chip_en   (chip_en),
        .wr_cen    (wr_cen),
        .cen_wdata (cen_wdata),
        .adjust    (wr_adjust),
        .inc       (inc),
        .corr      (corr),
        .carry_acc (carry_acc)
    );

    sec_bcd_counter u_sec (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_round (wr_adjust),
        .load      (wr_sec),
        .load_val  (preset),
        .inc       (inc),
        .sec       (sec),
        .min_req   (min_inc)
    );

    busy_window #(
        .CMD_TICKS   (CMD_TICKS),
        .CARRY_TICKS (CARRY_TICKS)
    ) u_busy (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_32k),
        .cmd_req   (wr_adjust | wr_divrst | corr),
        .carry_req (carry_acc),
        .busy      (busy)
    );

    // One-cycle divider reset on adjust or divider-reset command.
    always_ff @(posedge clk) begin
        if (!rst_n) div_rst_q <= 1'b0;
        else        div_rst_q <= wr_adjust | wr_divrst;
    end

    assign div_rst  = div_rst_q;
    assign sec_ones = sec.ones;
    assign sec_tens = sec.tens;

    AST_DIVRST_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_adjust || wr_divrst) |=> div_rst); // R6
    AST_BUSY_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_adjust || wr_divrst) |=> busy); // R9
    AST_DIVRST_SEC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_divrst && !wr_adjust && !wr_sec && !inc) |=> $stable(sec)); // R6

endmodule

// File: tb/sec_adjust_ctrl_tb.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against a reference model written from the requirements.
module sec_adjust_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_32k, carry_1hz, chip_en, wr_adjust, wr_divrst;
    logic       wr_cen, cen_wdata, wr_sec;
    logic [6:0] sec_wdata;
    logic [3:0] sec_ones;
    logic [2:0] sec_tens;
    logic       min_inc, div_rst, busy;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // model state
    int m_sec, m_cnt;
    bit m_cen, m_held, m_pend, m_min, m_div;

    always #2.5 clk = ~clk;

    sec_adjust_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .carry_1hz(carry_1hz),
        .chip_en(chip_en), .wr_adjust(wr_adjust), .wr_divrst(wr_divrst),
        .wr_cen(wr_cen), .cen_wdata(cen_wdata), .wr_sec(wr_sec),
        .sec_wdata(sec_wdata), .sec_ones(sec_ones), .sec_tens(sec_tens),
        .min_inc(min_inc), .div_rst(div_rst), .busy(busy)
    );

    function automatic int dut_sec();
        return int'(sec_tens) * 10 + int'(sec_ones);
    endfunction

    function automatic logic [6:0] to_bcd(input int v);
        return {3'(v / 10), 4'(v % 10)};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        tick_32k = 0; carry_1hz = 0; chip_en = 1; wr_adjust = 0; wr_divrst = 0;
        wr_cen = 0; cen_wdata = 0; wr_sec = 0; sec_wdata = '0;
    endtask

    // Advance the model by one clock using the current inputs.
    task automatic model_step();
        bit cen_n, rise, tp, missed, corr, inc, acc;
        int base, ld;
        cen_n  = !chip_en ? 1'b1 : (wr_cen ? cen_wdata : m_cen);
        rise   = cen_n && !m_cen;
        tp     = m_pend && tick_32k;
        missed = m_held || (!m_cen && (tp || carry_1hz));
        corr   = !wr_adjust && rise && missed;
        inc    = !wr_adjust && (corr || (tp && m_cen));
        acc    = !wr_adjust && carry_1hz && m_cen;
        base   = m_cnt - ((tick_32k && m_cnt != 0) ? 1 : 0);
        ld     = (wr_adjust || wr_divrst || corr) ? 4 : (acc ? 3 : 0);
        m_cnt  = (ld > base) ? ld : base;
        m_min  = wr_adjust ? (m_sec >= 30) : (!wr_sec && inc && m_sec == 59);
        m_div  = wr_adjust || wr_divrst;
        if (wr_adjust)   m_sec = 0;
        else if (wr_sec) m_sec = int'(sec_wdata[6:4]) * 10 + int'(sec_wdata[3:0]);
        else if (inc)    m_sec = (m_sec + 1) % 60;
        m_held = (wr_adjust || corr) ? 1'b0 : (m_held || (!m_cen && (tp || carry_1hz)));
        m_pend = wr_adjust ? 1'b0 : (acc || (m_pend && !tick_32k));
        m_cen  = cen_n;
    endtask

    // One clock: model follows the edge, outputs compared at the negedge.
    task automatic cyc();
        @(posedge clk);
        if (rst_n) model_step();
        @(negedge clk);
        if (rst_n) begin
            check("R2 seconds", dut_sec(), m_sec);
            check("R3 min_inc", int'(min_inc), int'(m_min));
            check("R6 div_rst", int'(div_rst), int'(m_div));
            check("R9 busy", int'(busy), int'(m_cnt != 0));
        end
        idle();
    endtask

    task automatic preset(input int v);
        wr_sec = 1; sec_wdata = to_bcd(v); cyc();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin tick_32k = 1; cyc(); end
    endtask

    initial begin
        #900000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        idle();
        rst_n = 0;
        m_sec = 0; m_cnt = 0; m_cen = 1; m_held = 0; m_pend = 0; m_min = 0; m_div = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 sec", dut_sec(), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 min_inc", int'(min_inc), 0);
        check("R1 div_rst", int'(div_rst), 0);

        // R12 preset, R2 carry then tick
        preset(8);
        check("R12 preset", dut_sec(), 8);
        carry_1hz = 1; cyc();
        check("R10 busy early", int'(busy), 1);
        check("R2 not yet", dut_sec(), 8);
        ticks(1);
        check("R2 ones", int'(sec_ones), 9);
        ticks(1);
        check("R10 busy mid", int'(busy), 1);
        ticks(1);
        check("R10 busy end", int'(busy), 0);

        // R3 wrap from 59
        preset(59);
        carry_1hz = 1; cyc();
        tick_32k = 1; cyc();
        check("R3 wrap sec", dut_sec(), 0);
        check("R3 min pulse", int'(min_inc), 1);
        cyc();
        check("R3 min once", int'(min_inc), 0);
        ticks(3);

        // R4 adjust at 29
        preset(29);
        wr_adjust = 1; cyc();
        check("R4 sec", dut_sec(), 0);
        check("R4 min", int'(min_inc), 0);
        check("R4 div", int'(div_rst), 1);
        // R9 command busy four ticks
        ticks(3);
        check("R9 busy 3 ticks", int'(busy), 1);
        ticks(1);
        check("R9 busy 4 ticks", int'(busy), 0);

        // R5 adjust at 30
        preset(30);
        wr_adjust = 1; cyc();
        check("R5 sec", dut_sec(), 0);
        check("R5 min", int'(min_inc), 1);
        ticks(4);

        // R6 divider reset leaves seconds
        preset(41);
        wr_divrst = 1; cyc();
        check("R6 div", int'(div_rst), 1);
        check("R6 sec kept", dut_sec(), 41);
        cyc();
        check("R6 div once", int'(div_rst), 0);
        ticks(4);

        // R7 pause: three carries, one +1 on resume
        preset(17);
        wr_cen = 1; cen_wdata = 0; cyc();
        for (int k = 0; k < 3; k++) begin
            carry_1hz = 1; cyc();
            ticks(2);
        end
        check("R7 paused", dut_sec(), 17);
        wr_cen = 1; cen_wdata = 1; cyc();
        check("R7 one replay", dut_sec(), 18);
        check("R9 corr busy", int'(busy), 1);
        ticks(4);
        // R7 resume with nothing missed
        wr_cen = 1; cen_wdata = 0; cyc();
        wr_cen = 1; cen_wdata = 1; cyc();
        check("R7 no replay", dut_sec(), 18);

        // R8 chip enable low forces resume
        wr_cen = 1; cen_wdata = 0; cyc();
        carry_1hz = 1; cyc();
        chip_en = 0; cyc();
        check("R8 forced resume", dut_sec(), 19);
        ticks(4);

        // R11 adjust with carry in same cycle, then while pending
        preset(12);
        carry_1hz = 1; wr_adjust = 1; cyc();
        ticks(5);
        check("R11 same cycle", dut_sec(), 0);
        preset(5);
        carry_1hz = 1; cyc();
        wr_adjust = 1; cyc();
        ticks(5);
        check("R11 pending dropped", dut_sec(), 0);

        // R12 load wins over increment
        preset(33);
        carry_1hz = 1; cyc();
        tick_32k = 1; wr_sec = 1; sec_wdata = to_bcd(50); cyc();
        check("R12 load wins", dut_sec(), 50);

        // random traffic against the model
        for (int n = 0; n < 6000; n++) begin
            tick_32k  = ($urandom_range(0, 5) == 0);
            carry_1hz = ($urandom_range(0, 39) == 0);
            wr_adjust = ($urandom_range(0, 199) == 0);
            wr_divrst = ($urandom_range(0, 149) == 0);
            wr_cen    = ($urandom_range(0, 59) == 0);
            cen_wdata = 1'($urandom_range(0, 1));
            chip_en   = ($urandom_range(0, 99) != 0);
            wr_sec    = ($urandom_range(0, 149) == 0);
            sec_wdata = to_bcd(int'($urandom_range(0, 59)));
            cyc();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule